// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Mode Permissions

This block caches virtual-to-physical page mappings for a data port. Every lookup presents a virtual address together with the access kind (read or write) and the privilege mode (kernel or user). The page-number part of the address is compared against the tags of all entries at once. A matching entry supplies a physical page number, which is joined to the unchanged page offset. The same entry also supplies read and write permissions for each mode, and these are checked before the access is allowed.

Each lookup ends in one of three results, reported one clock later: hit, miss or fault. A miss tells an outside agent to walk the page tables and write the mapping back through the fill port. A fault means that a mapping exists but the access is not permitted. One pulse on the flush input empties the whole buffer. With the default parameters there are 32 entries, a 43-bit virtual address, a 13-bit offset, 30-bit tags, 21-bit physical page numbers and a 34-bit physical address.

Top module: `xlat_buffer`

## Requirements
- R1: While reset is active and just after it is released, no entry is valid, all response outputs are low, and any lookup misses.
- R2: A lookup accepted on one clock edge is answered on the next edge with rsp_valid high. On a hit, rsp_paddr is the entry's physical page number placed above the 13 offset bits, and the offset bits are copied unchanged from the virtual address.
- R3: A lookup misses when no valid entry's tag equals virtual address bits [42:13]. Every response raises exactly one of hit, miss or fault, and rsp_paddr is zero whenever the result is not a hit.
- R4: Each entry has a 2-bit read field and a 2-bit write field. In each field, bit 0 grants kernel access and bit 1 grants user access. A matching lookup checks the write field for a write and the read field for a read, using the bit for the current mode. A clear bit gives a fault and no hit.
- R5: A fill whose tag already sits in a valid entry overwrites that entry. Otherwise the fill goes into the lowest-numbered invalid entry.
- R6: When every entry is valid and the fill tag is new, the victim is chosen by a rotating pointer. The pointer starts at entry 0 after reset and moves forward by one, wrapping after the last entry, each time it is used.
- R7: A flush makes every entry invalid within one cycle. A fill in the same cycle as a flush is dropped.
- R8: A lookup in the same cycle as a fill or a flush is judged against the contents held before that edge.
- R9: A cycle with lk_valid low produces a response cycle with rsp_valid, rsp_hit, rsp_miss and rsp_fault all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 43 | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| fill_en | input | 1 | Write a mapping |
| fill_vpn | input | 30 | Virtual page tag of the mapping |
| fill_ppn | input | 21 | Physical page number of the mapping |
| fill_rd | input | 2 | Read permission (bit 0 kernel, bit 1 user) |
| fill_wr | input | 2 | Write permission (bit 0 kernel, bit 1 user) |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation allowed |
| rsp_miss | output | 1 | No valid mapping |
| rsp_fault | output | 1 | Mapping present but permission denied |
| rsp_paddr | output | 34 | Physical address (zero unless hit) |

## Verification
A lookup can arrive in the same cycle as a fill or a flush that changes the entry it is looking for. This is provoked both directly and at random. The directed cases include a lookup of a tag in the same cycle as the fill that installs it, and a lookup of a resident tag in the same cycle as a flush. The bench model answers each lookup from its own copy of the contents taken before it applies that cycle's fill or flush. A result that already reflects the new contents is therefore reported as a mismatch against R8.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    // Permission bit positions inside each 2-bit field
    localparam int unsigned PERM_KERNEL = 0;
    localparam int unsigned PERM_USER   = 1;
    // Width of the packed permission pair {rd, wr}
    localparam int unsigned PERM_PAIR_W = 4;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int unsigned N     = 32,
    parameter int unsigned TAG_W = 30
) (
    input  logic [N-1:0]       vld,
    input  logic [N*TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]   key,
    output logic [N-1:0]       match
);
    // One comparator per entry, all evaluated in parallel
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = vld[g] && (tags[g*TAG_W +: TAG_W] == key);
    end
endmodule

// File: rtl/xlat_select.sv
module xlat_select #(
    parameter int unsigned N = 32,
    parameter int unsigned W = 25
) (
    input  logic [N-1:0]   sel,
    input  logic [N*W-1:0] data,
    output logic [W-1:0]   out
);
    // AND-OR selection: sel is at most one-hot
    logic [W-1:0] stage [N+1];
    assign stage[0] = '0;
    for (genvar g = 0; g < N; g++) begin : g_or
        assign stage[g+1] = stage[g] | (data[g*W +: W] & {W{sel[g]}});
    end
    assign out = stage[N];
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int unsigned N     = 32,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vld,
    input  logic [N-1:0]     match,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] idx,
    output logic             use_rr
);
    // Priority: existing tag, then lowest invalid, then rotating pointer
    always_comb begin
        idx    = rr_ptr;
        use_rr = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                idx    = IDX_W'(i);
                use_rr = 1'b0;
            end
        end
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                idx    = IDX_W'(i);
                use_rr = 1'b0;
            end
        end
    end
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer #(
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned VA_W    = 43,
    parameter int unsigned OFF_W   = 13,
    parameter int unsigned PPN_W   = 21
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic [VA_W-1:0]          lk_vaddr,
    input  logic                     lk_write,
    input  logic                     lk_user,
    input  logic                     fill_en,
    input  logic [VA_W-OFF_W-1:0]    fill_vpn,
    input  logic [PPN_W-1:0]         fill_ppn,
    input  logic [1:0]               fill_rd,
    input  logic [1:0]               fill_wr,
    input  logic                     flush,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic                     rsp_miss,
    output logic                     rsp_fault,
    output logic [PPN_W+OFF_W-1:0]   rsp_paddr
);
    import xlat_pkg::*;

    localparam int unsigned TAG_W = VA_W - OFF_W;
    localparam int unsigned PA_W  = PPN_W + OFF_W;
    localparam int unsigned IDX_W = $clog2(ENTRIES);
    localparam int unsigned PAY_W = PPN_W + PERM_PAIR_W;

    typedef struct packed {
        logic [ENTRIES-1:0]       vld;
        logic [ENTRIES*TAG_W-1:0] tags;
        logic [ENTRIES*PAY_W-1:0] pay;
        logic [IDX_W-1:0]         rr;
        logic                     rv;
        logic                     rh;
        logic                     rm;
        logic                     rf;
        logic [PA_W-1:0]          pa;
    } state_t;

    state_t st_q, st_d;

    logic [ENTRIES-1:0] lk_match, fill_match;
    logic [PAY_W-1:0]   lk_pay;
    logic [IDX_W-1:0]   fill_idx;
    logic               fill_use_rr;

    xlat_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_lk_match (
        .vld   (st_q.vld),
        .tags  (st_q.tags),
        .key   (lk_vaddr[VA_W-1:OFF_W]),
        .match (lk_match)
    );

    xlat_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_fill_match (
        .vld   (st_q.vld),
        .tags  (st_q.tags),
        .key   (fill_vpn),
        .match (fill_match)
    );

    xlat_select #(.N(ENTRIES), .W(PAY_W)) u_select (
        .sel  (lk_match),
        .data (st_q.pay),
        .out  (lk_pay)
    );

    xlat_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .vld    (st_q.vld),
        .match  (fill_match),
        .rr_ptr (st_q.rr),
        .idx    (fill_idx),
        .use_rr (fill_use_rr)
    );

    logic [PPN_W-1:0] sel_ppn;
    logic [1:0]       sel_rd, sel_wr;
    logic             allowed;

    assign sel_ppn = lk_pay[PAY_W-1:PERM_PAIR_W];
    assign sel_rd  = lk_pay[3:2];
    assign sel_wr  = lk_pay[1:0];
    assign allowed = lk_write ? sel_wr[lk_user ? PERM_USER : PERM_KERNEL]
                              : sel_rd[lk_user ? PERM_USER : PERM_KERNEL];

    always_comb begin
        st_d    = st_q;
        st_d.rv = lk_valid;
        st_d.rh = 1'b0;
        st_d.rm = 1'b0;
        st_d.rf = 1'b0;
        st_d.pa = '0;
        if (lk_valid) begin
            if (lk_match == '0) begin
                st_d.rm = 1'b1;
            end else if (allowed) begin
                st_d.rh = 1'b1;
                st_d.pa = {sel_ppn, lk_vaddr[OFF_W-1:0]};
            end else begin
                st_d.rf = 1'b1;
            end
        end
        if (flush) begin
            st_d.vld = '0;
        end else if (fill_en) begin
            st_d.vld[fill_idx]                 = 1'b1;
            st_d.tags[fill_idx*TAG_W +: TAG_W] = fill_vpn;
            st_d.pay[fill_idx*PAY_W +: PAY_W]  = {fill_ppn, fill_rd, fill_wr};
            if (fill_use_rr) begin
                st_d.rr = (st_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rv;
    assign rsp_hit   = st_q.rh;
    assign rsp_miss  = st_q.rm;
    assign rsp_fault = st_q.rf;
    assign rsp_paddr = st_q.pa;
endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk #(
    parameter int unsigned VA_W  = 43,
    parameter int unsigned OFF_W = 13,
    parameter int unsigned PPN_W = 21
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lk_valid,
    input logic [VA_W-1:0]        lk_vaddr,
    input logic                   flush,
    input logic                   rsp_valid,
    input logic                   rsp_hit,
    input logic                   rsp_miss,
    input logic                   rsp_fault,
    input logic [PPN_W+OFF_W-1:0] rsp_paddr
);
    p_resp_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rsp_hit || rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

    p_single_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

    p_nonhit_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> rsp_paddr == '0);

    p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && $past(flush)) |=> rsp_miss);

    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !(rsp_valid || rsp_hit || rsp_miss || rsp_fault));
endmodule

bind xlat_buffer xlat_buffer_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_vaddr  (lk_vaddr),
    .flush     (flush),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr)
);

// File: tb/xlat_buffer_tb.sv
`timescale 1ns/1ps
module xlat_buffer_tb_top;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [42:0] lk_vaddr = '0;
    logic        lk_write = 1'b0;
    logic        lk_user = 1'b0;
    logic        fill_en = 1'b0;
    logic [29:0] fill_vpn = '0;
    logic [20:0] fill_ppn = '0;
    logic [1:0]  fill_rd = '0;
    logic [1:0]  fill_wr = '0;
    logic        flush = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [33:0] rsp_paddr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    xlat_buffer dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_write(lk_write), .lk_user(lk_user), .fill_en(fill_en),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_rd(fill_rd),
        .fill_wr(fill_wr), .flush(flush), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr)
    );

    // Reference model of the contents
    bit          m_vld [N];
    logic [29:0] m_tag [N];
    logic [20:0] m_ppn [N];
    logic [1:0]  m_rd  [N];
    logic [1:0]  m_wr  [N];
    int          m_rr;

    function automatic int model_find(input logic [29:0] t);
        for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == t) return i;
        return -1;
    endfunction

    task automatic check_out(input string req, input logic ev, eh, em, ef,
                             input logic [33:0] epa);
        checks++;
        if ({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr} !== {ev, eh, em, ef, epa}) begin
            errors++;
            $display("FAIL %s: got v%0b h%0b m%0b f%0b pa=%h, expected v%0b h%0b m%0b f%0b pa=%h",
                     req, rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr,
                     ev, eh, em, ef, epa);
        end
    endtask

    // One cycle: drive at negedge, predict from old contents, check at next negedge
    task automatic step(input string req, input logic lkv, input logic [42:0] va,
                        input logic w, u, fe, input logic [29:0] fv,
                        input logic [20:0] fp, input logic [1:0] frd, fwr,
                        input logic fl);
        logic eh, em, ef, ok;
        logic [33:0] epa;
        int hit_i, idx;
        lk_valid = lkv; lk_vaddr = va; lk_write = w; lk_user = u;
        fill_en = fe; fill_vpn = fv; fill_ppn = fp; fill_rd = frd; fill_wr = fwr;
        flush = fl;
        eh = 0; em = 0; ef = 0; epa = '0;
        if (lkv) begin
            hit_i = model_find(va[42:13]);
            if (hit_i < 0) em = 1;
            else begin
                ok = w ? m_wr[hit_i][u] : m_rd[hit_i][u];
                if (ok) begin eh = 1; epa = {m_ppn[hit_i], va[12:0]}; end
                else ef = 1;
            end
        end
        if (fl) begin
            for (int i = 0; i < N; i++) m_vld[i] = 0;
        end else if (fe) begin
            idx = model_find(fv);
            if (idx < 0) for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) idx = i;
            if (idx < 0) begin idx = m_rr; m_rr = (m_rr + 1) % N; end
            m_vld[idx] = 1; m_tag[idx] = fv; m_ppn[idx] = fp;
            m_rd[idx] = frd; m_wr[idx] = fwr;
        end
        @(posedge clk);
        @(negedge clk);
        lk_valid = 0; fill_en = 0; flush = 0;
        check_out(req, lkv, eh, em, ef, epa);
    endtask

    task automatic look(input string req, input logic [29:0] t, input logic w, u);
        step(req, 1, {t, 13'($urandom)}, w, u, 0, '0, '0, '0, '0, 0);
    endtask

    task automatic put(input string req, input logic [29:0] t, input logic [20:0] p,
                       input logic [1:0] r, wv);
        step(req, 0, '0, 0, 0, 1, t, p, r, wv, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        m_rr = 0;
        for (int i = 0; i < N; i++) m_vld[i] = 0;
        repeat (3) @(negedge clk);
        check_out("R1 reset", 0, 0, 0, 0, '0);
        rst_n = 1;
        look("R1 empty after reset", 30'h1234, 0, 0);

        put("R9 fill without lookup", 30'h0000_00a1, 21'h1abcd, 2'b11, 2'b11);
        look("R2 kernel read hit", 30'h0000_00a1, 0, 0);
        look("R2 user write hit", 30'h0000_00a1, 1, 1);
        look("R3 miss on unknown tag", 30'h0000_00a2, 0, 0);

        put("R4 setup", 30'h0000_00b0, 21'h00b0b, 2'b01, 2'b10);
        look("R4 kernel read allowed", 30'h0000_00b0, 0, 0);
        look("R4 user read fault", 30'h0000_00b0, 0, 1);
        look("R4 kernel write fault", 30'h0000_00b0, 1, 0);
        look("R4 user write allowed", 30'h0000_00b0, 1, 1);

        step("R8 lookup with same-cycle fill", 1, {30'h0000_00c0, 13'h0042}, 0, 0,
             1, 30'h0000_00c0, 21'h0c0c0, 2'b11, 2'b11, 0);
        look("R8 fill visible next cycle", 30'h0000_00c0, 0, 0);

        put("R5 overwrite existing tag", 30'h0000_00a1, 21'h05555, 2'b11, 2'b00);
        look("R5 new mapping", 30'h0000_00a1, 0, 1);
        look("R5 new permissions", 30'h0000_00a1, 1, 0);

        step("R8 lookup with same-cycle flush", 1, {30'h0000_00c0, 13'h1fff}, 0, 0,
             1, 30'h0000_00d0, 21'h0d0d0, 2'b11, 2'b11, 1);
        look("R7 flush cleared", 30'h0000_00c0, 0, 0);
        look("R7 fill dropped by flush", 30'h0000_00d0, 0, 0);

        for (int i = 0; i < N; i++)
            put("R5 fill lowest invalid", 30'(32'h100 + i), 21'(32'h200 + i), 2'b11, 2'b11);
        put("R6 victim at pointer 0", 30'h0000_0300, 21'h00300, 2'b11, 2'b11);
        look("R6 entry 0 evicted", 30'h0000_0100, 0, 0);
        put("R6 victim at pointer 1", 30'h0000_0301, 21'h00301, 2'b11, 2'b11);
        look("R6 entry 1 evicted", 30'h0000_0101, 0, 0);
        look("R6 entry 2 kept", 30'h0000_0102, 0, 0);
        look("R6 new entry present", 30'h0000_0301, 1, 1);

        for (int n = 0; n < 4000; n++) begin
            logic [29:0] tl, tf;
            tl = 30'(32'h400 + ($urandom % 44));
            tf = 30'(32'h400 + ($urandom % 44));
            step("R8 random mix", 1'($urandom % 4 != 0), {tl, 13'($urandom)},
                 1'($urandom), 1'($urandom), 1'($urandom % 3 == 0), tf,
                 21'($urandom), 2'($urandom), 2'($urandom), 1'($urandom % 97 == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule